// File: doc/BRIEF.md
# Run-Length Frame Synchronizer and Cell Decoder

This block sits behind a frequency-shift demodulator in a proximity-card receiver. It takes one demodulated symbol (0 or 1) per input strobe and recovers the tag's data bits. The block hunts for a frame header: a long stretch of 0 symbols followed directly by a long stretch of 1 symbols. The first 0 symbol after the header opens the data section. From that point the stream is cut into bit cells of 10 to 12 symbols. A cell decodes as 1 when the symbol level flips somewhere inside it, and as 0 when the level holds steady across the cell.

Cell timing follows the incoming edges. A level flip that arrives once a cell already holds at least the minimum number of symbols is taken as the boundary of the next cell. This keeps cell-length jitter from adding up over a long frame. A cell that reaches its maximum length with no flip closes on the following symbol. After a set number of bits the decoder returns to hunting, so a tag that repeats its frame is picked up again on every header. A malformed cell aborts the frame with a one-cycle error pulse.

Top module: `rl_frame_decoder`

## Requirements
- R1: While reset is held and in the cycle after it is released, bit_valid, frame_start and frame_err are all low.
- R2: A run of more than ZERO_MIN (default 20) zero symbols, then at least ONE_MIN (default 15) one symbols, then a zero symbol produces one frame_start pulse in the cycle after that zero symbol is accepted. That zero symbol is the first symbol of the first data cell.
- R3: A zero run of exactly ZERO_MIN symbols followed by ones does not open a frame: no frame_start and no bits.
- R4: A one run shorter than ONE_MIN after a valid zero run does not open a frame: no frame_start and no bits.
- R5: Each closed cell gives one bit_valid pulse in the cycle after its closing symbol is accepted. bit_out is 1 if a level flip occurred inside the cell and 0 if there was none.
- R6: A flip that arrives when the open cell holds CELL_MIN (10) or more symbols closes the cell and starts a new one with that symbol. A cell that holds CELL_MAX (12) symbols with no flip closes on the next symbol when that symbol does not flip. Cells of 10, 11 and 12 symbols therefore all decode correctly.
- R7: A second flip inside one cell, before it holds CELL_MIN symbols, pulses frame_err for one cycle. No further bits are given until a new header is seen.
- R8: In the data section, a steady run of more than RUN_MAX (default 24) identical symbols pulses frame_err and abandons the frame.
- R9: After NUM_BITS (default 44) bits the decoder stops giving bits until a new header. Back-to-back frames are each decoded in full.
- R10: Cycles with sym_valid low have no effect: sym_in is ignored and none of bit_valid, frame_start or frame_err is raised in the cycle that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sym_valid | input | 1 | Strobe: sym_in holds a new symbol this cycle |
| sym_in | input | 1 | Demodulated symbol level |
| bit_out | output | 1 | Decoded bit value, meaningful while bit_valid is high |
| bit_valid | output | 1 | One-cycle strobe per decoded bit |
| frame_start | output | 1 | One-cycle pulse when a header has been recognized |
| frame_err | output | 1 | One-cycle pulse when a frame is aborted |

## Verification
The hardest case to reach from the ports is a cell boundary that falls right at the edge of the allowed window. One such case is a flip arriving exactly at the tenth symbol. Another is a steady cell of twelve symbols whose close depends on the next symbol not flipping. The case where the last cell of a frame closes only when trailing symbols of the following header arrive is also hard to reach. The stimulus builds frames from random bits with random cell lengths and random flip positions. It adds directed frames with every cell at 10 and every cell at 12 symbols, and it always ends a frame with a zero tail. Directed streams make the header thresholds miss by exactly one symbol, insert a cell with two inner flips, and hold the level steady past the run limit. Random idle gaps with a toggling sym_in separate the symbols throughout.

// File: rtl/rlfd_pkg.sv
package rlfd_pkg;

    // Decoder control states.
    typedef enum logic [1:0] {
        ST_HUNT_ZEROS = 2'd0,
        ST_COUNT_ONES = 2'd1,
        ST_DATA       = 2'd2,
        ST_ERROR      = 2'd3
    } rlfd_state_e;

    // Registered output bundle of the decoder.
    typedef struct packed {
        logic frame_start;
        logic bit_valid;
        logic bit_val;
        logic frame_err;
    } rlfd_out_t;

    // Number of bits needed to hold the value max_val.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/rl_run_tracker.sv
module rl_run_tracker #(
    parameter int RUN_CAP = 64,
    parameter int RUN_W   = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    input  logic             sym,
    output logic             level_o,
    output logic [RUN_W-1:0] run_o,
    output logic [RUN_W-1:0] run_next_o,
    output logic             edge_o
);
    logic             level_q;
    logic [RUN_W-1:0] run_q;

    // A symbol differing from the held level starts a new run.
    assign edge_o     = (sym != level_q);
    assign run_next_o = edge_o ? RUN_W'(1) :
                        (run_q == RUN_W'(RUN_CAP)) ? run_q : run_q + RUN_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            level_q <= 1'b0;
            run_q   <= '0;
        end else if (step) begin
            level_q <= sym;
            run_q   <= run_next_o;
        end
    end

    assign level_o = level_q;
    assign run_o   = run_q;
endmodule

// File: rtl/rl_bit_cell.sv
module rl_bit_cell #(
    parameter int CELL_MIN = 10,
    parameter int CELL_MAX = 12,
    parameter int CELL_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              step,
    input  logic              edge_i,
    output logic [CELL_W-1:0] cnt_o,
    output logic              close_o,
    output logic              bit_o,
    output logic              twice_o
);
    logic [CELL_W-1:0] cnt_q;
    logic              mid_q;
    logic              late;

    assign late    = (cnt_q >= CELL_W'(CELL_MIN));
    // Boundary: a late flip, or a full cell followed by a steady symbol.
    assign close_o = step && ((edge_i && late) || (!edge_i && cnt_q >= CELL_W'(CELL_MAX)));
    // A second early flip inside the same cell is malformed.
    assign twice_o = step && edge_i && !late && mid_q;
    assign bit_o   = mid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            mid_q <= 1'b0;
        end else if (start) begin
            cnt_q <= CELL_W'(1);
            mid_q <= 1'b0;
        end else if (step) begin
            if (close_o) begin
                cnt_q <= CELL_W'(1);
                mid_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + CELL_W'(1);
                if (edge_i) mid_q <= 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/rl_frame_decoder.sv
module rl_frame_decoder
    import rlfd_pkg::*;
#(
    parameter int ZERO_MIN = 20,
    parameter int ONE_MIN  = 15,
    parameter int CELL_MIN = 10,
    parameter int CELL_MAX = 12,
    parameter int RUN_MAX  = 24,
    parameter int NUM_BITS = 44
) (
    input  logic clk,
    input  logic rst,
    input  logic sym_valid,
    input  logic sym_in,
    output logic bit_out,
    output logic bit_valid,
    output logic frame_start,
    output logic frame_err
);
    localparam int RUN_CAP = ZERO_MIN + ONE_MIN + RUN_MAX + 1;
    localparam int RUN_W   = cnt_width(RUN_CAP);
    localparam int CELL_W  = cnt_width(CELL_MAX);
    localparam int BIT_W   = cnt_width(NUM_BITS);

    rlfd_state_e      state_q, state_d;
    logic [BIT_W-1:0] bits_q, bits_d;
    rlfd_out_t        out_q, out_d;

    logic             level_w;
    logic [RUN_W-1:0] run_w, run_nx;
    logic             edge_w;

    logic [CELL_W-1:0] cell_cnt;
    logic              cell_start, cell_step;
    logic              cell_close, cell_bit, cell_twice;

    rl_run_tracker #(
        .RUN_CAP(RUN_CAP),
        .RUN_W  (RUN_W)
    ) u_run (
        .clk       (clk),
        .rst       (rst),
        .step      (sym_valid),
        .sym       (sym_in),
        .level_o   (level_w),
        .run_o     (run_w),
        .run_next_o(run_nx),
        .edge_o    (edge_w)
    );

    assign cell_step = sym_valid && (state_q == ST_DATA);

    rl_bit_cell #(
        .CELL_MIN(CELL_MIN),
        .CELL_MAX(CELL_MAX),
        .CELL_W  (CELL_W)
    ) u_cell (
        .clk    (clk),
        .rst    (rst),
        .start  (cell_start),
        .step   (cell_step),
        .edge_i (edge_w),
        .cnt_o  (cell_cnt),
        .close_o(cell_close),
        .bit_o  (cell_bit),
        .twice_o(cell_twice)
    );

    always_comb begin
        state_d    = state_q;
        bits_d     = bits_q;
        out_d      = '0;
        cell_start = 1'b0;
        unique case (state_q)
            ST_HUNT_ZEROS: begin
                // Rising flip that ends a long enough zero run.
                if (sym_valid && edge_w && sym_in && !level_w &&
                    run_w > RUN_W'(ZERO_MIN))
                    state_d = ST_COUNT_ONES;
            end
            ST_COUNT_ONES: begin
                if (sym_valid && edge_w) begin
                    if (run_w >= RUN_W'(ONE_MIN)) begin
                        state_d           = ST_DATA;
                        cell_start        = 1'b1;
                        out_d.frame_start = 1'b1;
                        bits_d            = '0;
                    end else begin
                        state_d = ST_HUNT_ZEROS;
                    end
                end
            end
            ST_DATA: begin
                if (sym_valid) begin
                    if (cell_twice || (!edge_w && run_nx > RUN_W'(RUN_MAX))) begin
                        state_d         = ST_ERROR;
                        out_d.frame_err = 1'b1;
                    end else if (cell_close) begin
                        out_d.bit_valid = 1'b1;
                        out_d.bit_val   = cell_bit;
                        if (bits_q == BIT_W'(NUM_BITS - 1)) begin
                            state_d = ST_HUNT_ZEROS;
                            bits_d  = '0;
                        end else begin
                            bits_d = bits_q + BIT_W'(1);
                        end
                    end
                end
            end
            ST_ERROR: state_d = ST_HUNT_ZEROS;
            default:  state_d = ST_HUNT_ZEROS;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HUNT_ZEROS;
            bits_q  <= '0;
            out_q   <= '0;
        end else begin
            state_q <= state_d;
            bits_q  <= bits_d;
            out_q   <= out_d;
        end
    end

    assign bit_out     = out_q.bit_val;
    assign bit_valid   = out_q.bit_valid;
    assign frame_start = out_q.frame_start;
    assign frame_err   = out_q.frame_err;
endmodule

// File: rtl/rl_frame_decoder_chk.sv
module rl_frame_decoder_chk
    import rlfd_pkg::*;
#(
    parameter int CELL_MAX = 12,
    parameter int CELL_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              sym_valid,
    input logic              sym_in,
    input logic              bit_valid,
    input logic              frame_start,
    input logic              frame_err,
    input rlfd_state_e       state,
    input logic [CELL_W-1:0] cell_cnt
);
    assert_start_on_zero_R2: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ($past(sym_valid) && !$past(sym_in)));

    assert_bit_after_symbol_R5: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(sym_valid));

    assert_cell_bounded_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DATA) |-> (cell_cnt <= CELL_W'(CELL_MAX)));

    assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
        frame_err |=> !frame_err);

    assert_events_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start, bit_valid, frame_err}));

    assert_bits_in_data_R9: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(state == ST_DATA));

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !$past(sym_valid) |-> !(bit_valid || frame_start || frame_err));
endmodule

bind rl_frame_decoder rl_frame_decoder_chk #(
    .CELL_MAX(CELL_MAX),
    .CELL_W  (CELL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .sym_valid  (sym_valid),
    .sym_in     (sym_in),
    .bit_valid  (bit_valid),
    .frame_start(frame_start),
    .frame_err  (frame_err),
    .state      (state_q),
    .cell_cnt   (cell_cnt)
);

// File: tb/rl_frame_decoder_bench.sv
module rl_frame_decoder_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_BITS   = 44;
    localparam int LOG_DEPTH  = 1024;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sym_valid = 1'b0;
    logic sym_in = 1'b0;
    logic bit_out, bit_valid, frame_start, frame_err;

    int n_checks = 0;
    int n_fail   = 0;
    int nbits = 0, nfs = 0, nerr = 0;
    logic got  [0:LOG_DEPTH-1];
    logic expb [0:127];
    logic lvl = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rl_frame_decoder #(.NUM_BITS(NUM_BITS)) u_rl_frame_decoder (
        .clk        (clk),
        .rst        (rst),
        .sym_valid  (sym_valid),
        .sym_in     (sym_in),
        .bit_out    (bit_out),
        .bit_valid  (bit_valid),
        .frame_start(frame_start),
        .frame_err  (frame_err)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (!rst) begin
            if (bit_valid) begin
                if (nbits < LOG_DEPTH) got[nbits] = bit_out;
                nbits = nbits + 1;
            end
            if (frame_start) nfs = nfs + 1;
            if (frame_err) nerr = nerr + 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Mismatches between logged bits from base and the first n expected bits.
    function automatic int mismatches(input int base, input int n);
        int m = 0;
        for (int i = 0; i < n; i++)
            if (base + i >= LOG_DEPTH || got[base + i] !== expb[i]) m++;
        return m;
    endfunction

    // One accepted symbol, then a random idle gap with a junk sym_in.
    task automatic put(input logic s);
        @(negedge clk);
        sym_in = s; sym_valid = 1'b1; lvl = s;
        @(negedge clk);
        sym_valid = 1'b0; sym_in = 1'($urandom);
        repeat ($urandom_range(0, 2)) @(negedge clk);
    endtask

    task automatic put_run(input logic s, input int n);
        for (int i = 0; i < n; i++) put(s);
    endtask

    // Cell: flips at its first symbol; a 1 cell flips again at position m.
    task automatic put_cell(input logic b, input int len);
        logic a;
        int   m;
        a = ~lvl;
        m = b ? int'($urandom_range(3, 8)) : len + 1;
        for (int p = 1; p <= len; p++) put((p < m) ? a : ~a);
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    // lmode 0: random cell lengths, otherwise every cell lmode symbols.
    task automatic send_frame(input int nz, input int no, input int lmode);
        put_run(1'b1, 3);
        put_run(1'b0, nz);
        put_run(1'b1, no);
        for (int i = 0; i < NUM_BITS; i++) begin
            expb[i] = 1'($urandom);
            put_cell(expb[i], (lmode == 0) ? int'($urandom_range(10, 12)) : lmode);
        end
        put_run(1'b0, 13);
        settle();
    endtask

    task automatic frame_case(input string req, input int nz, input int no, input int lmode);
        int b0, f0, e0;
        b0 = nbits; f0 = nfs; e0 = nerr;
        send_frame(nz, no, lmode);
        check(nfs - f0 == 1, "R2", {req, " frame_start count"}, nfs - f0, 1);
        check(nbits - b0 == NUM_BITS, "R9", {req, " bits per frame"}, nbits - b0, NUM_BITS);
        check(mismatches(b0, NUM_BITS) == 0, "R5", {req, " bit values (R10 gaps)"},
              mismatches(b0, NUM_BITS), 0);
        check(nerr == e0, "R6", {req, " no error"}, nerr - e0, 0);
    endtask

    initial begin
        int b0, f0, e0;
        logic a;
        void'($urandom(32'd9137));

        repeat (5) @(negedge clk);
        check(!bit_valid && !frame_start && !frame_err, "R1", "outputs in reset",
              {bit_valid, frame_start, frame_err}, 0);
        rst = 1'b0;
        @(negedge clk);
        check(!bit_valid && !frame_start && !frame_err, "R1", "outputs after reset",
              {bit_valid, frame_start, frame_err}, 0);

        // R2 boundary header: 21 zeros, 15 ones.
        frame_case("R2 minimal header", 21, 15, 0);
        // R6 all-short and all-long cells.
        frame_case("R6 cells of 10", 24, 18, 10);
        frame_case("R6 cells of 12", 24, 18, 12);
        // R9 back-to-back random frames.
        for (int k = 0; k < 4; k++)
            frame_case("R9 repeated frame", int'($urandom_range(21, 30)),
                       int'($urandom_range(15, 25)), 0);

        // R10 idle cycles with toggling symbol.
        b0 = nbits; f0 = nfs; e0 = nerr;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            sym_in = 1'($urandom);
        end
        settle();
        check(nbits == b0 && nfs == f0 && nerr == e0, "R10", "idle toggles give no event",
              (nbits - b0) + (nfs - f0) + (nerr - e0), 0);

        // R3 zero run of exactly ZERO_MIN.
        b0 = nbits; f0 = nfs;
        put_run(1'b1, 3); put_run(1'b0, 20); put_run(1'b1, 20);
        for (int i = 0; i < 6; i++) put_cell(1'($urandom), 11);
        put_run(1'b0, 13); settle();
        check(nfs == f0 && nbits == b0, "R3", "20 zeros rejected", nfs - f0 + nbits - b0, 0);

        // R4 one run one short of ONE_MIN.
        b0 = nbits; f0 = nfs;
        put_run(1'b1, 3); put_run(1'b0, 30); put_run(1'b1, 14);
        for (int i = 0; i < 6; i++) put_cell(1'($urandom), 11);
        put_run(1'b0, 13); settle();
        check(nfs == f0 && nbits == b0, "R4", "14 ones rejected", nfs - f0 + nbits - b0, 0);

        // R7 double flip inside a cell.
        b0 = nbits; f0 = nfs; e0 = nerr;
        put_run(1'b1, 3); put_run(1'b0, 25); put_run(1'b1, 16);
        expb[0] = 1'b1; expb[1] = 1'b0; expb[2] = 1'b1;
        for (int i = 0; i < 3; i++) put_cell(expb[i], 11);
        a = ~lvl;
        put_run(a, 3); put_run(~a, 3); put_run(a, 4);
        for (int i = 0; i < 5; i++) put_cell(1'($urandom), 11);
        put_run(1'b0, 13); settle();
        check(nerr - e0 == 1, "R7", "error pulses", nerr - e0, 1);
        check(nbits - b0 == 3, "R7", "bits before abort only", nbits - b0, 3);
        check(mismatches(b0, 3) == 0, "R7", "bits before abort", mismatches(b0, 3), 0);

        // R8 steady run too long in data; R6 12-symbol steady cell closes.
        b0 = nbits; f0 = nfs; e0 = nerr;
        put_run(1'b1, 3); put_run(1'b0, 22); put_run(1'b1, 15);
        put_run(1'b0, 30); put_run(1'b1, 3); put_run(1'b0, 13); settle();
        check(nfs - f0 == 1, "R2", "header before long run", nfs - f0, 1);
        check(nbits - b0 == 1, "R6", "one steady cell closed", nbits - b0, 1);
        check(b0 < LOG_DEPTH && got[b0] === 1'b0, "R6", "steady cell value", int'(got[b0]), 0);
        check(nerr - e0 == 1, "R8", "long run aborts", nerr - e0, 1);

        // R9 no bits past NUM_BITS without a new header.
        b0 = nbits; f0 = nfs;
        put_run(1'b1, 3); put_run(1'b0, 26); put_run(1'b1, 19);
        for (int i = 0; i < NUM_BITS; i++) begin
            expb[i] = 1'($urandom);
            put_cell(expb[i], int'($urandom_range(10, 12)));
        end
        for (int i = 0; i < 8; i++) put_cell(1'($urandom), 11);
        put_run(1'b0, 13); settle();
        check(nbits - b0 == NUM_BITS, "R9", "bit count capped", nbits - b0, NUM_BITS);
        check(mismatches(b0, NUM_BITS) == 0, "R5", "capped frame values",
              mismatches(b0, NUM_BITS), 0);

        // R2 resync after errors and trailing cells.
        frame_case("R2 resync", 21, 15, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule